// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block sits behind the comparator bank of a flash converter. It takes the 63-line thermometer word, in which bit k is 1 when the input lies above threshold k, and turns it into a registered 6-bit binary code. All registers switch on the falling clock edge. The word is captured on one falling edge. On the next falling edge, each line is compared with the two lines above it, which gives a one-hot word that is not disturbed by an isolated comparator error. On the falling edge after that, six wide OR trees reduce the one-hot word to the binary code. The code therefore appears two clock cycles after its sample was taken.

A small state machine tracks pipeline fill after reset. In state HOLD, reset is active. The first falling edge with reset released moves HOLD to FILL1. The next edge moves FILL1 to FILL2, and the edge after that moves FILL2 to LIVE. The machine stays in LIVE until reset. Any falling edge with reset active returns it to HOLD. The valid flag is high only in LIVE, so it rises at the same edge as the first code built from a real sample.

Top module: `therm_bin_encoder`

## Requirements
- R1: A clean thermometer word holds ones in bits 0 to L-1 and zeros above. For every L from 0 to 63, such a word gives code L. All zeros gives 0 and all ones gives 63.
- R2: A clean word of level L (L at least 2) with exactly one of its lower ones cleared, at any bit j from 0 to L-2, still gives code L.
- R3: A one-hot line k is set when bit k is 1 and bits k+1 and k+2 are 0. Bits above 62 count as 0. Line k stands for code k+1. So a level-L word with a stray 1 at bit L+1 (bit L being 0) gives code L+2.
- R4: When several one-hot lines are set, the code is the bitwise OR of their code values, and no error is signalled. Example: level L with a stray 1 at bit L+3 gives L | (L+4).
- R5: A word present at a falling edge appears on `code` at the second falling edge after it, with a new word accepted every cycle.
- R6: Reset is active-low and synchronous to the falling edge. A falling edge with `rst_n` low clears `code` to 0 and `valid` to 0.
- R7: Count the falling edges with `rst_n` high after a reset. `valid` stays 0 at the first and second of these edges, goes to 1 at the third, and then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst_n | input | 1 | Active-low synchronous reset |
| therm | input | 63 | Thermometer word, bit k from comparator k |
| code | output | 6 | Registered binary code |
| valid | output | 1 | High once the pipeline holds real samples |

## Verification
The bench streams one word per cycle and checks each result two cycles later. Every clean level from 0 to 63 is applied; this separates each of the 64 codes and shows that each output bit collects the right lines. Every single-zero bubble under every level is applied; these show the window check hides lower errors. Words with a stray 1 one or three positions above the top are applied; the first shows how a stray 1 inside the window is resolved, and the second shows how two live lines are merged by OR. Reset is applied both at start-up and mid-stream, to time the fill sequence of the valid flag and the clearing of a nonzero code.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_FILL1 = 2'd1,
        ST_FILL2 = 2'd2,
        ST_LIVE  = 2'd3
    } ttb_state_e;
endpackage

// File: rtl/ttb_capture.sv
module ttb_capture #(
    parameter int WIDTH = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // sample the comparator word on the falling edge
    always_ff @(negedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ttb_window.sv
module ttb_window #(
    parameter int WIDTH = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] therm_q,
    output logic [WIDTH-1:0] onehot_q
);
    localparam int PADW = WIDTH + 2;
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [PADW-1:0]  padded;
    logic [WIDTH-1:0] onehot_d;

    assign padded = {2'b00, therm_q};

    // line k: own bit high, two bits above both low
    for (genvar k = 0; k < WIDTH; k++) begin : g_line
        assign onehot_d[k] = padded[k] & ~padded[k+1] & ~padded[k+2];
    end

    always_ff @(negedge clk) begin
        if (!rst_n) onehot_q <= '0;
        else        onehot_q <= onehot_d;
    end

    // a clean nonzero level always yields exactly one live line
    p_clean_one_line_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (((therm_q & (therm_q + ONE)) == '0) && (therm_q != '0))
        |=> ($countones(onehot_q) == 1));

    // an all-zero word leaves every line low
    p_zero_no_line_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (therm_q == '0) |=> (onehot_q == '0));
endmodule

// File: rtl/ttb_or_tree.sv
module ttb_or_tree #(
    parameter int CODE_W = 6,
    parameter int WIDTH  = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  onehot_q,
    output logic [CODE_W-1:0] code_q
);
    logic [CODE_W-1:0] code_d;

    // lines whose code value (index + 1) carries bit b
    function automatic logic [WIDTH-1:0] line_mask(input int b);
        logic [WIDTH-1:0] m;
        m = '0;
        for (int k = 0; k < WIDTH; k++) begin
            m[k] = (((k + 1) >> b) & 1) == 1;
        end
        return m;
    endfunction

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        localparam logic [WIDTH-1:0] MASK = line_mask(b);
        assign code_d[b] = |(onehot_q & MASK);
    end

    always_ff @(negedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    p_empty_zero_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (onehot_q == '0) |=> (code_q == '0));

    // top line forces every bit, whatever else is merged in
    p_top_line_r4: assert property (@(negedge clk) disable iff (!rst_n)
        onehot_q[WIDTH-1] |=> (&code_q));
endmodule

// File: rtl/ttb_valid_fsm.sv
module ttb_valid_fsm
    import ttb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic valid
);
    ttb_state_e state, state_nx;

    always_ff @(negedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_HOLD:  state_nx = ST_FILL1;
            ST_FILL1: state_nx = ST_FILL2;
            ST_FILL2: state_nx = ST_LIVE;
            ST_LIVE:  state_nx = ST_LIVE;
            default:  state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_LIVE: valid = 1'b1;
            default: valid = 1'b0;
        endcase
    end

    p_valid_sticky_r7: assert property (@(negedge clk) disable iff (!rst_n)
        valid |=> valid);

    p_fill_to_live_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (state == ST_FILL2) |=> valid);
endmodule

// File: rtl/therm_bin_encoder.sv
module therm_bin_encoder #(
    parameter  int CODE_W  = 6,
    localparam int THERM_W = (1 << CODE_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [THERM_W-1:0] therm,
    output logic [CODE_W-1:0]  code,
    output logic               valid
);
    logic [THERM_W-1:0] therm_q;
    logic [THERM_W-1:0] onehot_q;

    ttb_capture #(.WIDTH(THERM_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (therm),
        .q     (therm_q)
    );

    ttb_window #(.WIDTH(THERM_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .therm_q  (therm_q),
        .onehot_q (onehot_q)
    );

    ttb_or_tree #(.CODE_W(CODE_W), .WIDTH(THERM_W)) u_or_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .onehot_q (onehot_q),
        .code_q   (code)
    );

    ttb_valid_fsm u_valid_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (valid)
    );

    // a clean full-scale word reaches code 63 two edges later
    p_full_scale_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (&therm_q) |=> ##1 (&code));
endmodule

// File: tb/therm_bin_encoder_bench.sv
`timescale 1ns/1ps
module therm_bin_encoder_bench;
    localparam int CW = 6;
    localparam int TW = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] therm;
    logic [CW-1:0] code;
    logic          valid;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [CW-1:0] hist [3];
    bit            hv   [3];
    string         hr   [3];

    always #5 clk = ~clk;

    therm_bin_encoder #(.CODE_W(CW)) u_therm_bin_encoder (
        .clk   (clk),
        .rst_n (rst_n),
        .therm (therm),
        .code  (code),
        .valid (valid)
    );

    function automatic logic [TW-1:0] level(input int l);
        logic [TW:0] w;
        w = (({{TW{1'b0}}, 1'b1}) << l) - 1'b1;
        return w[TW-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: check the word from three steps back, then drive a new one
    task automatic step(input logic [TW-1:0] w, input int e, input string req, input bit live);
        @(posedge clk);
        #1;
        if (hv[2]) chk((code == hist[2]) && valid, hr[2], int'(code), int'(hist[2]));
        hist[2] = hist[1]; hv[2] = hv[1]; hr[2] = hr[1];
        hist[1] = hist[0]; hv[1] = hv[0]; hr[1] = hr[0];
        therm   = w;
        hist[0] = CW'(e); hv[0] = live; hr[0] = req;
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) step('0, 0, "flush", 1'b0);
    endtask

    // valid must be low for two samples after release, then high
    task automatic release_and_check_fill();
        @(posedge clk); #1; rst_n = 1'b1;
        @(posedge clk); #1; chk(valid == 1'b0, "R7 fill1", valid, 0);
        @(posedge clk); #1; chk(valid == 1'b0, "R7 fill2", valid, 0);
        @(posedge clk); #1; chk(valid == 1'b1, "R7 live", valid, 1);
        chk(code == '0, "R6 code after reset", int'(code), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; hist[i] = '0; hr[i] = ""; end
        rst_n = 1'b0;
        therm = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(code == '0, "R6 reset code", int'(code), 0);
        chk(valid == 1'b0, "R6 reset valid", valid, 0);
        release_and_check_fill();

        // R1 and R5: every clean level, streamed back to back
        for (int l = 0; l <= TW; l++) step(level(l), l, "R1 clean level", 1'b1);
        // R2: every single low bubble under every level
        for (int l = 2; l <= TW; l++)
            for (int j = 0; j <= l - 2; j++)
                step(level(l) & ~(TW'(1) << j), l, "R2 low bubble", 1'b1);
        // R3: stray one just above the gap
        for (int l = 0; l <= TW - 2; l++)
            step(level(l) | (TW'(1) << (l + 1)), l + 2, "R3 stray above", 1'b1);
        // R4: two live lines merged by OR
        for (int l = 0; l <= TW - 4; l++)
            step(level(l) | (TW'(1) << (l + 3)), l | (l + 4), "R4 merged lines", 1'b1);
        drain();

        // R6: mid-stream reset clears a nonzero code
        for (int i = 0; i < 4; i++) step(level(40), 40, "R5 hold level", 1'b1);
        #0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk(code == '0, "R6 mid-stream code", int'(code), 0);
        chk(valid == 1'b0, "R6 mid-stream valid", valid, 0);
        for (int i = 0; i < 3; i++) hv[i] = 1'b0;
        therm = '0;
        release_and_check_fill();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule